// File: doc/BRIEF.md
# Flat or Two-Level Table Entry Walker

This block looks up one 64-bit entry in a table held in memory, given a numeric identifier. A start pulse samples the identifier and the table configuration. The configuration is a base address, the page size and the entry size (both as log2 values), and a mode bit that picks a flat table or a two-level table. The block then issues one or two 64-bit reads on a simple memory port. Each read is a request that is held until a response arrives. A response may carry an error.

In flat mode the entry is read directly. In two-level mode the first read fetches a level-1 descriptor. If that descriptor is marked valid, its low address bits point at a level-2 page, and the second read fetches the entry from that page. Because both sizes are powers of two, all index arithmetic reduces to shifts and masks. The result is presented with a one-cycle done pulse. The result holds an entry word, an entry-valid flag and an error flag, and it stays put until the next accepted start.

Top module: `tbl_entry_walker`

## Requirements
- R1: In flat mode (`cfg_indirect`=0) exactly one read is issued, at `cfg_base` + id*8.
- R2: In two-level mode the first read is at `cfg_base` + (id / (2^`cfg_page_log2` / 8))*8.
- R3: A level-1 descriptor whose bit 63 is clear ends the walk without a second read, giving `ent_valid`=0, `ent_data`=0 and `ent_err`=0.
- R4: With bit 63 of the descriptor set, the second read is at descriptor[50:0] + (id mod 2^(`cfg_page_log2`-`cfg_ent_log2`))*8. Descriptor bits 63..51 play no part in this address.
- R5: When the final read succeeds, `ent_data` is the returned word and `ent_valid` equals its bit 0.
- R6: A response with `mem_rsp_err`=1 on any read ends the walk at once, giving `ent_err`=1, `ent_valid`=0 and `ent_data`=0.
- R7: `busy` is high from the cycle after an accepted start until the done cycle, inclusive. `done` is high for exactly one cycle, the cycle after the final response.
- R8: `mem_req` stays high with a constant `mem_addr` until `mem_rsp_valid` is seen.
- R9: A `start` while `busy` is high is ignored and does not disturb the walk in progress.
- R10: An accepted start clears the three result outputs. Outside a walk they hold their last value.
- R11: After reset `busy`, `done` and `mem_req` are low and all results are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a lookup (accepted when idle) |
| id | input | ID_W | Identifier to look up |
| cfg_base | input | AW | Table base address (flat table or level-1 array) |
| cfg_page_log2 | input | LW | log2 of page size in bytes (at least 3) |
| cfg_ent_log2 | input | LW | log2 of entry size in bytes (3 up to page log2) |
| cfg_indirect | input | 1 | 1 selects the two-level walk |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Read request, held until response |
| mem_addr | output | AW | Read byte address |
| mem_rsp_valid | input | 1 | Read response present |
| mem_rsp_data | input | 64 | Read data |
| mem_rsp_err | input | 1 | Read response is an error |
| ent_data | output | 64 | Fetched entry |
| ent_valid | output | 1 | Entry valid flag |
| ent_err | output | 1 | Memory error seen during walk |

## Verification
The hardest cases to reach from the ports are a second-level read that fails after a good descriptor, and a new start that lands while a read is still outstanding. In both, the walk has already left its first step. The bench holds a modelled memory whose responses it withholds for a chosen number of cycles. It injects an error on the second read only, and raises `start` with a different identifier during the wait. It then checks that the held address and the final outcome are those of the original lookup. Identifiers on both sides of a page boundary, and descriptors with junk above bit 50, exercise the index split and the address masking.

// File: rtl/tbl_entry_walker.sv
module tbl_entry_walker #(
  parameter int AW   = 64,
  parameter int ID_W = 32,
  parameter int LW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [ID_W-1:0] id,
  input  logic [AW-1:0]   cfg_base,
  input  logic [LW-1:0]   cfg_page_log2,
  input  logic [LW-1:0]   cfg_ent_log2,
  input  logic            cfg_indirect,
  output logic            busy,
  output logic            done,
  output logic            mem_req,
  output logic [AW-1:0]   mem_addr,
  input  logic            mem_rsp_valid,
  input  logic [63:0]     mem_rsp_data,
  input  logic            mem_rsp_err,
  output logic [63:0]     ent_data,
  output logic            ent_valid,
  output logic            ent_err
);
  localparam int DESC_VLD = 63;
  localparam int PTR_W    = 51;

  typedef enum logic [1:0] {S_IDLE, S_L1, S_L2, S_DONE} st_t;

  st_t             st;
  logic [ID_W-1:0] id_q;
  logic [LW-1:0]   slots_log2_q;
  logic [AW-1:0]   rd_addr;

  logic [LW-1:0] l1_shift;
  logic [AW-1:0] l1_addr, flat_addr, slot_mask, l2_addr;

  assign l1_shift  = cfg_page_log2 - LW'(3);
  assign l1_addr   = cfg_base + ((AW'(id) >> l1_shift) << 3);
  assign flat_addr = cfg_base + (AW'(id) << 3);
  assign slot_mask = (AW'(1) << slots_log2_q) - AW'(1);
  assign l2_addr   = AW'(mem_rsp_data[PTR_W-1:0]) + ((AW'(id_q) & slot_mask) << 3);

  assign busy     = (st != S_IDLE);
  assign done     = (st == S_DONE);
  assign mem_req  = (st == S_L1) || (st == S_L2);
  assign mem_addr = rd_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      id_q         <= '0;
      slots_log2_q <= '0;
      rd_addr      <= '0;
      ent_data     <= '0;
      ent_valid    <= 1'b0;
      ent_err      <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          id_q         <= id;
          slots_log2_q <= cfg_page_log2 - cfg_ent_log2;
          ent_data     <= '0;
          ent_valid    <= 1'b0;
          ent_err      <= 1'b0;
          rd_addr      <= cfg_indirect ? l1_addr : flat_addr;
          st           <= cfg_indirect ? S_L1 : S_L2;
        end
        S_L1: if (mem_rsp_valid) begin
          if (mem_rsp_err) begin
            ent_err <= 1'b1;
            st      <= S_DONE;
          end else if (!mem_rsp_data[DESC_VLD]) begin
            st      <= S_DONE;
          end else begin
            rd_addr <= l2_addr;
            st      <= S_L2;
          end
        end
        S_L2: if (mem_rsp_valid) begin
          if (mem_rsp_err) begin
            ent_err <= 1'b1;
          end else begin
            ent_data  <= mem_rsp_data;
            ent_valid <= mem_rsp_data[0];
          end
          st <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tbl_entry_walker_chk.sv
module tbl_entry_walker_chk #(
  parameter int AW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          mem_rsp_valid,
  input logic          mem_rsp_err,
  input logic [63:0]   ent_data,
  input logic          ent_valid,
  input logic          ent_err
);
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_done_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy && !mem_req);

  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rsp_valid |=> mem_req && $stable(mem_addr));

  a_r6_err_ends: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_rsp_valid && mem_rsp_err |=> done && ent_err && !ent_valid && (ent_data == 64'd0));

  a_r5_valid_bit: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ent_valid == ent_data[0]));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(ent_data) && $stable(ent_valid) && $stable(ent_err));

  a_r9_req_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);
endmodule

bind tbl_entry_walker tbl_entry_walker_chk #(.AW(AW)) u_chk (.*);

// File: tb/tbl_entry_walker_test.sv
module tbl_entry_walker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] id = '0;
  logic [63:0] cfg_base = '0;
  logic [4:0]  cfg_page_log2 = 5'd12;
  logic [4:0]  cfg_ent_log2 = 5'd3;
  logic        cfg_indirect = 1'b0;
  logic        busy, done, mem_req;
  logic [63:0] mem_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        mem_rsp_err = 1'b0;
  logic [63:0] ent_data;
  logic        ent_valid, ent_err;

  int vectors = 0;
  int fails = 0;
  logic [63:0] mem [longint unsigned];

  always #4 clk = ~clk;

  tbl_entry_walker uut (.*);

  function automatic logic [63:0] rd(longint unsigned a);
    return mem.exists(a) ? mem[a] : 64'd0;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  task automatic serve(string req, longint unsigned a, bit err, int lat, bit poke);
    for (int k = 0; k <= lat; k++) begin
      chk("R8 req", 64'(mem_req), 64'd1);
      chk(k == 0 ? req : (poke ? "R9 addr" : "R8 addr"), mem_addr, a);
      chk("R7 busy", 64'(busy), 64'd1);
      chk("R7 done", 64'(done), 64'd0);
      if (k < lat) begin
        if (poke && k == 0) begin
          start = 1'b1;
          id = ~id;
          cfg_base = cfg_base + 64'h100;
        end
        @(posedge clk); @(negedge clk);
        start = 1'b0;
      end else begin
        mem_rsp_valid = 1'b1;
        mem_rsp_err = err;
        mem_rsp_data = err ? 64'hDEAD_BEEF_DEAD_BEEF : rd(a);
        @(posedge clk); @(negedge clk);
        mem_rsp_valid = 1'b0;
        mem_rsp_err = 1'b0;
        mem_rsp_data = '0;
      end
    end
  endtask

  task automatic walk(logic [31:0] wid, longint unsigned base, int plog, int elog,
                      bit ind, int lat, int err_at, bit poke);
    longint unsigned a1, a2, page, slots;
    logic [63:0] d1, ed;
    logic ev, ee;
    page  = 64'd1 << plog;
    slots = page >> elog;
    start = 1'b1; id = wid; cfg_base = base;
    cfg_page_log2 = 5'(plog); cfg_ent_log2 = 5'(elog); cfg_indirect = ind;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    chk("R10 clr data", ent_data, 64'd0);
    chk("R10 clr valid", 64'(ent_valid), 64'd0);
    chk("R10 clr err", 64'(ent_err), 64'd0);
    if (ind) a1 = base + (64'(wid) / (page / 8)) * 8;
    else     a1 = base + 64'(wid) * 8;
    serve(ind ? "R2 l1 addr" : "R1 flat addr", a1, err_at == 1, lat, poke);
    d1 = rd(a1);
    ed = '0; ev = 1'b0; ee = 1'b0;
    if (err_at == 1) ee = 1'b1;
    else if (!ind) begin ed = d1; ev = d1[0]; end
    else if (!d1[63]) begin
      chk("R3 no 2nd read", 64'(mem_req), 64'd0);
    end else begin
      a2 = (d1 & ((64'd1 << 51) - 1)) + (64'(wid) % slots) * 8;
      serve("R4 l2 addr", a2, err_at == 2, lat, 1'b0);
      if (err_at == 2) ee = 1'b1;
      else begin ed = rd(a2); ev = ed[0]; end
    end
    chk("R7 done pulse", 64'(done), 64'd1);
    chk(ee ? "R6 data" : (ind && !d1[63]) ? "R3 data" : "R5 data", ent_data, ed);
    chk(ee ? "R6 valid" : "R5 valid", 64'(ent_valid), 64'(ev));
    chk(ee ? "R6 err" : "R3 err", 64'(ent_err), 64'(ee));
    @(posedge clk); @(negedge clk);
    chk("R7 done low", 64'(done), 64'd0);
    chk("R7 busy low", 64'(busy), 64'd0);
    chk("R1 no extra req", 64'(mem_req), 64'd0);
    id = ~wid;
    @(posedge clk); @(negedge clk);
    chk("R10 hold data", ent_data, ed);
    chk("R10 hold valid", 64'(ent_valid), 64'(ev));
    chk("R10 hold err", 64'(ent_err), 64'(ee));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    mem[64'h1028] = 64'h0000_0000_1234_5671;
    mem[64'h1030] = 64'hABCD_0000_0000_0010;
    mem[64'h8008] = 64'h8080_0000_0002_0000;
    mem[64'h20F40] = 64'h5555_0000_0000_00A3;
    mem[64'h20740] = 64'h0000_7777_0000_0001;
    mem[64'h8040] = 64'h0000_0000_0003_0000;
    mem[64'h8000] = 64'h8000_0000_0003_0000;
    mem[64'h30FF8] = 64'h0000_0000_0000_0BB1;
    mem[64'h20000] = 64'h0000_0000_0000_0CC0;

    repeat (3) @(negedge clk);
    chk("R11 busy", 64'(busy), 64'd0);
    chk("R11 done", 64'(done), 64'd0);
    chk("R11 req", 64'(mem_req), 64'd0);
    chk("R11 data", ent_data, 64'd0);
    chk("R11 valid", 64'(ent_valid), 64'd0);
    chk("R11 err", 64'(ent_err), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    walk(32'd5,    64'h1000, 12, 3, 1'b0, 0, 0, 1'b0);
    walk(32'd6,    64'h1000, 12, 3, 1'b0, 2, 0, 1'b0);
    walk(32'd1000, 64'h8000, 12, 3, 1'b1, 1, 0, 1'b0);
    walk(32'd1000, 64'h8000, 12, 4, 1'b1, 0, 0, 1'b0);
    walk(32'd70000, 64'h8000, 16, 3, 1'b1, 2, 0, 1'b0);
    walk(32'd511,  64'h8000, 12, 3, 1'b1, 0, 0, 1'b0);
    walk(32'd512,  64'h8000, 12, 3, 1'b1, 3, 0, 1'b0);
    walk(32'd1000, 64'h8000, 12, 3, 1'b1, 1, 1, 1'b0);
    walk(32'd1000, 64'h8000, 12, 3, 1'b1, 2, 2, 1'b0);
    walk(32'd5,    64'h1000, 12, 3, 1'b0, 1, 1, 1'b0);
    walk(32'd5,    64'h1000, 12, 3, 1'b0, 3, 0, 1'b1);
    walk(32'd1000, 64'h8000, 12, 3, 1'b1, 2, 0, 1'b1);
    walk(32'd1000, 64'h8000, 12, 4, 1'b1, 2, 2, 1'b1);
    summary();
  end
endmodule